// File: doc/BRIEF.md
# Prioritized Interrupt Distributor

This block collects a parameterized set of raw interrupt lines and presents them to one processor through a single request output. Each line has its own enable, a five-bit urgency level, a trigger mode (active-high level or rising edge) and a stored target byte. A global distributor enable and a processor-side control bit gate delivery. A priority mask limits which urgency levels may interrupt the processor.

Software reads an acknowledge register to learn which source to service. That read returns the most urgent pending source, moves it from pending to active, and removes it from arbitration. Writing the source number to an end-of-interrupt register ends the active state. A level line that is still high at that point becomes pending again.

The register bus works on 32-bit words. Write and read strobes are one cycle long, and read data comes from a register.

Top module: `irq_distributor`

## Requirements
- R1: After reset all sources are disabled, the distributor and processor enables read 0, every priority and the mask read 0, `irq_out` is low, and the acknowledge register (word 0x03) reads 1023.
- R2: The priority of source n sits in byte n mod 4 of word 0x20 + n/4. Only bits 7..3 are stored, bits 2..0 always read as zero, and 0 is the most urgent value.
- R3: The trigger code of source n sits at bits 2(n mod 16)+1..2(n mod 16) of word 0x10 + n/16. Code 01 is active-high level and 11 is rising edge. Sources 0..15 always read 10 and act as edge sources. For sources 16 and up, the low bit always reads 1 and the high bit is writable. These sources reset to 01.
- R4: The target byte of source n sits in byte n mod 4 of word 0x40 + n/4. It is writable only for n >= 32 and reads 0 below that.
- R5: Word 0x08 + k (enable-set) and word 0x0C + k (enable-clear) cover sources 32k..32k+31, bit for bit. A 1 written to enable-set enables the source, a 1 written to enable-clear disables it, and a 0 written to either changes nothing. Both words read the current enables.
- R6: While bit 0 of the distributor control word (0x00) is 0, `irq_out` stays low and an acknowledge read returns 1023.
- R7: An acknowledge read returns the enabled, pending, non-active source with the numerically lowest priority among those whose priority is below the mask. On a priority tie the lowest source number wins. The read makes that source active and clears its pending state.
- R8: When no source qualifies, an acknowledge read returns 1023 and leaves every active and pending state unchanged.
- R9: Writing a source number to word 0x04 ends that source's active state. An active source is never returned again before this write. A level source that is still high afterwards is pending again.
- R10: An edge source becomes pending on a rising edge of its input and stays pending after the input falls, until it is acknowledged. A level source is pending only while its input is high.
- R11: The mask word (0x02) keeps bits 7..3, and its low bits read zero. A source qualifies only when its priority is strictly below the mask. Bit 0 of the processor control word (0x01) gates `irq_out` but not the acknowledge result.
- R12: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read. `irq_out` is registered: it changes one clock after the state that selects the winner changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per word |
| bus_re | input | 1 | Read strobe, one cycle per word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | NUM_SRC | Raw interrupt lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Read data is due one clock after the read strobe. Each read pushes its expected word into a queue, and a monitor pops that word after the capturing edge, half a cycle away from any edge. A raised input becomes pending at the next edge, and `irq_out` follows one edge later. The bench therefore waits at least three cycles after changing inputs before it checks `irq_out` or acknowledges. The one check of exact timing samples `irq_out` low at the first falling edge after the enabling write, then high at the next one. State changes caused by an acknowledge or end-of-interrupt take effect at the edge that captures the access, so the next access in the bench already sees them.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 5;
  localparam int unsigned IDX_W  = 5;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_DCTRL,
    RG_CCTRL,
    RG_PMASK,
    RG_ACK,
    RG_EOI,
    RG_ENSET,
    RG_ENCLR,
    RG_CFG,
    RG_PRIO,
    RG_TGT
  } region_e;
endpackage

// File: rtl/irqd_src_bank.sv
module irqd_src_bank
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_in,
  input  logic                      wr_en,
  input  region_e                   wr_rg,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [31:0]               wr_data,
  input  logic                      ack_fire,
  input  logic [ID_W-1:0]           ack_id,
  input  logic                      eoi_fire,
  input  logic [ID_W-1:0]           eoi_id,
  output logic [NUM_SRC-1:0]        en_q,
  output logic [NUM_SRC-1:0]        pend_q,
  output logic [NUM_SRC-1:0]        act_q,
  output logic [NUM_SRC*PRIO_W-1:0] prio_q,
  output logic [NUM_SRC*2-1:0]      cfg_rd,
  output logic [NUM_SRC*8-1:0]      tgt_rd
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned W4  = i / 4;
    localparam int unsigned B4  = i % 4;
    localparam int unsigned W16 = i / 16;
    localparam int unsigned B16 = i % 16;
    localparam int unsigned W32 = i / 32;
    localparam int unsigned B32 = i % 32;

    logic              en_r, en_d;
    logic              pend_r, pend_d;
    logic              act_r, act_d;
    logic              line_q;
    logic              edge_mode;
    logic [PRIO_W-1:0] prio_r, prio_d;
    logic              hit_ack, hit_eoi;

    assign hit_ack = ack_fire && (ack_id == ID_W'(i));
    assign hit_eoi = eoi_fire && (eoi_id == ID_W'(i));

    always_comb begin
      en_d = en_r;
      if (wr_en && wr_rg == RG_ENSET && wr_idx == IDX_W'(W32) && wr_data[B32])
        en_d = 1'b1;
      if (wr_en && wr_rg == RG_ENCLR && wr_idx == IDX_W'(W32) && wr_data[B32])
        en_d = 1'b0;
      prio_d = prio_r;
      if (wr_en && wr_rg == RG_PRIO && wr_idx == IDX_W'(W4))
        prio_d = wr_data[B4*8+3 +: PRIO_W];
      act_d = (act_r | hit_ack) & ~hit_eoi;
      if (edge_mode)
        pend_d = (pend_r & ~hit_ack) | (src_in[i] & ~line_q);
      else
        pend_d = src_in[i] & ~act_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        pend_r <= 1'b0;
        act_r  <= 1'b0;
        line_q <= 1'b0;
        prio_r <= '0;
      end else begin
        en_r   <= en_d;
        pend_r <= pend_d;
        act_r  <= act_d;
        line_q <= src_in[i];
        prio_r <= prio_d;
      end
    end

    if (i < 16) begin : g_fixed_cfg
      assign edge_mode = 1'b1;
      assign cfg_rd[2*i +: 2] = 2'b10;
    end else begin : g_prog_cfg
      logic edge_r, edge_d;
      always_comb begin
        edge_d = edge_r;
        if (wr_en && wr_rg == RG_CFG && wr_idx == IDX_W'(W16))
          edge_d = wr_data[2*B16+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_r <= 1'b0;
        else        edge_r <= edge_d;
      end
      assign edge_mode = edge_r;
      assign cfg_rd[2*i +: 2] = {edge_r, 1'b1};
    end

    if (i >= 32) begin : g_tgt
      logic [7:0] tgt_r, tgt_d;
      always_comb begin
        tgt_d = tgt_r;
        if (wr_en && wr_rg == RG_TGT && wr_idx == IDX_W'(W4))
          tgt_d = wr_data[B4*8 +: 8];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgt_r <= '0;
        else        tgt_r <= tgt_d;
      end
      assign tgt_rd[8*i +: 8] = tgt_r;
    end else begin : g_no_tgt
      assign tgt_rd[8*i +: 8] = 8'h00;
    end

    assign en_q[i]                   = en_r;
    assign pend_q[i]                 = pend_r;
    assign act_q[i]                  = act_r;
    assign prio_q[i*PRIO_W +: PRIO_W] = prio_r;

    // R9: an end-of-interrupt for this source leaves it inactive
    p_eoi_drops_active_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_eoi |=> !act_r);
  end

endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dist_en,
  input  logic [PRIO_W-1:0]         mask,
  input  logic [NUM_SRC-1:0]        en,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        act,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      win_valid,
  output logic [ID_W-1:0]           win_id,
  output logic [PRIO_W-1:0]         win_prio
);

  logic [PRIO_W-1:0] parr [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign parr[i] = prio[i*PRIO_W +: PRIO_W];
    assign elig[i] = dist_en & en[i] & pend[i] & ~act[i] & (parr[i] < mask);
  end

  // strict compare while scanning upward keeps the lowest ID on a tie
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_valid || parr[i] < win_prio)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_prio  = parr[i];
      end
    end
  end

  // R11: a winner always lies strictly below the mask
  p_win_below_mask_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_prio < mask));
  // R6: no winner while the distributor is off
  p_no_win_when_off_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en |-> !win_valid);

endmodule

// File: rtl/irqd_regif.sv
module irqd_regif
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_we,
  input  logic                      bus_re,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_SRC-1:0]        en_q,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_q,
  input  logic [NUM_SRC*2-1:0]      cfg_rd,
  input  logic [NUM_SRC*8-1:0]      tgt_rd,
  input  logic                      win_valid,
  input  logic [ID_W-1:0]           win_id,
  output logic                      dist_en,
  output logic                      cpu_en,
  output logic [PRIO_W-1:0]         mask,
  output logic                      wr_en,
  output region_e                   wr_rg,
  output logic [IDX_W-1:0]          wr_idx,
  output logic                      ack_fire,
  output logic [ID_W-1:0]           ack_id,
  output logic                      eoi_fire,
  output logic [ID_W-1:0]           eoi_id
);

  localparam int unsigned N32 = NUM_SRC / 32;
  localparam int unsigned N16 = NUM_SRC / 16;
  localparam int unsigned N4  = NUM_SRC / 4;
  localparam int unsigned A_ENSET = 8;
  localparam int unsigned A_ENCLR = 12;
  localparam int unsigned A_CFG   = 16;
  localparam int unsigned A_PRIO  = 32;
  localparam int unsigned A_TGT   = 64;

  region_e          rg;
  logic [IDX_W-1:0] idx;
  logic [9:0]       sel;
  logic [NUM_SRC*8-1:0] prio8;
  logic             dist_d, cpu_d;
  logic [PRIO_W-1:0] mask_d;
  logic [31:0]      rd_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_p8
    assign prio8[8*i +: 8] = {prio_q[i*PRIO_W +: PRIO_W], 3'b000};
  end

  always_comb begin
    rg  = RG_NONE;
    idx = '0;
    if (bus_addr == ADDR_W'(0))      rg = RG_DCTRL;
    else if (bus_addr == ADDR_W'(1)) rg = RG_CCTRL;
    else if (bus_addr == ADDR_W'(2)) rg = RG_PMASK;
    else if (bus_addr == ADDR_W'(3)) rg = RG_ACK;
    else if (bus_addr == ADDR_W'(4)) rg = RG_EOI;
    else if (bus_addr >= ADDR_W'(A_ENSET) && bus_addr < ADDR_W'(A_ENSET + N32)) begin
      rg  = RG_ENSET;
      idx = IDX_W'(bus_addr - ADDR_W'(A_ENSET));
    end else if (bus_addr >= ADDR_W'(A_ENCLR) && bus_addr < ADDR_W'(A_ENCLR + N32)) begin
      rg  = RG_ENCLR;
      idx = IDX_W'(bus_addr - ADDR_W'(A_ENCLR));
    end else if (bus_addr >= ADDR_W'(A_CFG) && bus_addr < ADDR_W'(A_CFG + N16)) begin
      rg  = RG_CFG;
      idx = IDX_W'(bus_addr - ADDR_W'(A_CFG));
    end else if (bus_addr >= ADDR_W'(A_PRIO) && bus_addr < ADDR_W'(A_PRIO + N4)) begin
      rg  = RG_PRIO;
      idx = IDX_W'(bus_addr - ADDR_W'(A_PRIO));
    end else if (bus_addr >= ADDR_W'(A_TGT) && bus_addr < ADDR_W'(A_TGT + N4)) begin
      rg  = RG_TGT;
      idx = IDX_W'(bus_addr - ADDR_W'(A_TGT));
    end
  end

  assign sel      = {idx, 5'b00000};
  assign wr_en    = bus_we;
  assign wr_rg    = rg;
  assign wr_idx   = idx;
  assign ack_fire = bus_re && (rg == RG_ACK) && win_valid;
  assign ack_id   = win_id;
  assign eoi_fire = bus_we && (rg == RG_EOI) && (bus_wdata[ID_W-1:0] < ID_W'(NUM_SRC));
  assign eoi_id   = bus_wdata[ID_W-1:0];

  always_comb begin
    dist_d = dist_en;
    cpu_d  = cpu_en;
    mask_d = mask;
    if (bus_we && rg == RG_DCTRL) dist_d = bus_wdata[0];
    if (bus_we && rg == RG_CCTRL) cpu_d  = bus_wdata[0];
    if (bus_we && rg == RG_PMASK) mask_d = bus_wdata[7:3];
  end

  always_comb begin
    rd_d = 32'h0;
    case (rg)
      RG_DCTRL: rd_d = {31'h0, dist_en};
      RG_CCTRL: rd_d = {31'h0, cpu_en};
      RG_PMASK: rd_d = {24'h0, mask, 3'b000};
      RG_ACK:   rd_d = {22'h0, (win_valid ? win_id : SPURIOUS_ID)};
      RG_ENSET,
      RG_ENCLR: rd_d = en_q[sel +: 32];
      RG_CFG:   rd_d = cfg_rd[sel +: 32];
      RG_PRIO:  rd_d = prio8[sel +: 32];
      RG_TGT:   rd_d = tgt_rd[sel +: 32];
      default:  rd_d = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en   <= 1'b0;
      cpu_en    <= 1'b0;
      mask      <= '0;
      bus_rdata <= '0;
    end else begin
      dist_en <= dist_d;
      cpu_en  <= cpu_d;
      mask    <= mask_d;
      if (bus_re) bus_rdata <= rd_d;
    end
  end

  // R12: read data holds when no read was issued
  p_rdata_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_out
);

  localparam int unsigned SRC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]        en_q, pend_q, act_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [NUM_SRC*2-1:0]      cfg_rd;
  logic [NUM_SRC*8-1:0]      tgt_rd;
  logic                      win_valid;
  logic [ID_W-1:0]           win_id;
  logic [PRIO_W-1:0]         win_prio;
  logic                      dist_en, cpu_en;
  logic [PRIO_W-1:0]         mask;
  logic                      wr_en;
  region_e                   wr_rg;
  logic [IDX_W-1:0]          wr_idx;
  logic                      ack_fire, eoi_fire;
  logic [ID_W-1:0]           ack_id, eoi_id;
  logic                      irq_d, irq_q;
  logic [SRC_W-1:0]          ack_sel;

  irqd_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_q(en_q), .prio_q(prio_q), .cfg_rd(cfg_rd), .tgt_rd(tgt_rd),
    .win_valid(win_valid), .win_id(win_id),
    .dist_en(dist_en), .cpu_en(cpu_en), .mask(mask),
    .wr_en(wr_en), .wr_rg(wr_rg), .wr_idx(wr_idx),
    .ack_fire(ack_fire), .ack_id(ack_id),
    .eoi_fire(eoi_fire), .eoi_id(eoi_id)
  );

  irqd_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(irq_src),
    .wr_en(wr_en), .wr_rg(wr_rg), .wr_idx(wr_idx), .wr_data(bus_wdata),
    .ack_fire(ack_fire), .ack_id(ack_id),
    .eoi_fire(eoi_fire), .eoi_id(eoi_id),
    .en_q(en_q), .pend_q(pend_q), .act_q(act_q),
    .prio_q(prio_q), .cfg_rd(cfg_rd), .tgt_rd(tgt_rd)
  );

  irqd_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .mask(mask),
    .en(en_q), .pend(pend_q), .act(act_q), .prio(prio_q),
    .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
  );

  assign irq_d = cpu_en & win_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_out = irq_q;
  assign ack_sel = ack_id[SRC_W-1:0];

  // R7: the acknowledged source is active after the read
  p_ack_marks_active_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> act_q[$past(ack_sel)]);
  // R8: an acknowledge with no winner leaves active state alone
  p_spurious_keeps_state_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(3) && !win_valid) |=> $stable(act_q));
  // R6, R11: a request needs both enables one cycle earlier
  p_irq_needs_enables_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(dist_en && cpu_en));

endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
  localparam int NSRC = 64;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_we, bus_re;
  logic [7:0]       bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [NSRC-1:0]  irq_src;
  logic             irq_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_distributor #(.NUM_SRC(NSRC), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s irq_out actual=%b expected=%b", t, irq_out, e);
    end
  endtask

  // monitor: read data is due one edge after the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re === 1'b1) begin
        logic [31:0] e;
        string t;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0;
    bus_wdata = '0; irq_src = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(8'h03, 32'd1023, "R1 ack");
    rd(8'h00, 32'h0, "R1 dctrl");
    rd(8'h02, 32'h0, "R1 mask");
    rd(8'h08, 32'h0, "R1 enables");
    rd(8'h20, 32'h0, "R1 prio");
    // R3 reset configuration
    rd(8'h10, 32'hAAAAAAAA, "R3 fixed ids");
    rd(8'h11, 32'h55555555, "R3 reset level");

    // R2 low priority bits dropped
    wr(8'h28, 32'hFFFFFFFF);
    rd(8'h28, 32'hF8F8F8F8, "R2");
    // R3 read-only bits
    wr(8'h12, 32'h00000000);
    rd(8'h12, 32'h55555555, "R3 low bit ro");
    wr(8'h12, 32'hFFFFFFFF);
    rd(8'h12, 32'hFFFFFFFF, "R3 edge");
    wr(8'h10, 32'h00000000);
    rd(8'h10, 32'hAAAAAAAA, "R3 fixed");
    wr(8'h12, 32'h00000000);
    // R4 targets
    wr(8'h40, 32'h01010101);
    rd(8'h40, 32'h0, "R4 low ids");
    wr(8'h48, 32'h01020304);
    rd(8'h48, 32'h01020304, "R4 high ids");
    // R5 enables
    wr(8'h09, 32'h5);
    rd(8'h09, 32'h5, "R5 set");
    wr(8'h0D, 32'h4);
    rd(8'h09, 32'h1, "R5 clear");
    rd(8'h0D, 32'h1, "R5 clear word reads");
    wr(8'h09, 32'h0);
    rd(8'h09, 32'h1, "R5 zero no effect");

    // R11 mask low bits
    wr(8'h28, 32'h00000040);
    wr(8'h02, 32'hF7);
    rd(8'h02, 32'hF0, "R11 mask");
    wr(8'h01, 32'h1);

    // R6 distributor off
    @(negedge clk); irq_src[32] = 1'b1;
    idle(3);
    chk_irq(1'b0, "R6");
    rd(8'h03, 32'd1023, "R6 ack");
    // R12 exact request timing
    wr(8'h00, 32'h1);
    chk_irq(1'b0, "R12 not yet");
    idle(1);
    chk_irq(1'b1, "R12 due");

    // R7 / R8 / R9
    rd(8'h03, 32'd32, "R7");
    idle(2);
    chk_irq(1'b0, "R9 active hidden");
    rd(8'h03, 32'd1023, "R8");
    wr(8'h04, 32'd32);
    idle(2);
    chk_irq(1'b1, "R9 level again");
    rd(8'h03, 32'd32, "R9");
    @(negedge clk); irq_src[32] = 1'b0;
    wr(8'h04, 32'd32);
    idle(3);
    chk_irq(1'b0, "R10 level gone");
    rd(8'h03, 32'd1023, "R10 level gone ack");

    // R7 priority and tie order
    wr(8'h09, 32'h6);
    wr(8'h28, 32'h00202040);
    @(negedge clk); irq_src[34:32] = 3'b111;
    idle(3);
    rd(8'h03, 32'd33, "R7 tie low id");
    rd(8'h03, 32'd34, "R7 tie second");
    rd(8'h03, 32'd32, "R7 least urgent");
    rd(8'h03, 32'd1023, "R8 all active");
    @(negedge clk); irq_src[34:32] = 3'b000;
    wr(8'h04, 32'd33);
    wr(8'h04, 32'd34);
    wr(8'h04, 32'd32);
    idle(3);
    chk_irq(1'b0, "R9 all retired");

    // R11 mask comparison
    wr(8'h28, 32'h0020F040);
    @(negedge clk); irq_src[33] = 1'b1;
    wr(8'h02, 32'hF0);
    idle(3);
    chk_irq(1'b0, "R11 equal masked");
    rd(8'h03, 32'd1023, "R11 equal masked ack");
    wr(8'h02, 32'hF8);
    idle(2);
    chk_irq(1'b1, "R11 below mask");
    rd(8'h03, 32'd33, "R11 ack");
    @(negedge clk); irq_src[33] = 1'b0;
    wr(8'h04, 32'd33);

    // R11 processor enable gates only the output
    @(negedge clk); irq_src[32] = 1'b1;
    wr(8'h01, 32'h0);
    idle(3);
    chk_irq(1'b0, "R11 cpu off");
    rd(8'h03, 32'd32, "R11 cpu off ack");
    @(negedge clk); irq_src[32] = 1'b0;
    wr(8'h04, 32'd32);
    wr(8'h01, 32'h1);

    // R10 edge versus level
    wr(8'h12, 32'h000000C0);
    rd(8'h12, 32'h555555D5, "R3 edge id35");
    wr(8'h09, 32'h8);
    @(negedge clk); irq_src[35] = 1'b1; irq_src[34] = 1'b1;
    @(negedge clk); irq_src[35] = 1'b0; irq_src[34] = 1'b0;
    idle(3);
    rd(8'h03, 32'd35, "R10 edge latched");
    rd(8'h03, 32'd1023, "R10 level pulse lost");
    wr(8'h04, 32'd35);
    @(negedge clk); irq_src[35] = 1'b1;
    idle(3);
    rd(8'h03, 32'd35, "R10 rising");
    wr(8'h04, 32'd35);
    idle(3);
    rd(8'h03, 32'd1023, "R10 held high no edge");
    @(negedge clk); irq_src[35] = 1'b0;

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule